// File: doc/BRIEF.md
# Receive Watermark FIFO

This block holds received serial words between the deserializer and the system bus. Words come in on a write strobe and leave through a read strobe that stands for a read of the receive data register. The block derives two status flags from the number of stored words. The full flag shows that every slot is occupied. The data-request flag shows that the fill level is strictly above a programmable watermark. Both flags only have meaning while reception is enabled. Turning reception off forces both flags low at once and empties the store on the next clock edge.

The data-request flag can drive a DMA engine or a CPU interrupt. In DMA mode it appears on the DMA request output, and its CPU interrupt contribution is masked. Each DMA acknowledge strobe pulls the flag low for one cycle. If the level is still above the watermark, the flag comes back on the cycle after. A write that finds the store full is discarded and sets a sticky overflow indicator. A read from an empty store returns zero and changes nothing.

Top module: `rx_wm_fifo`

## Requirements
- R1: With reception enabled, a write strobe stores the word when the store is not full, or when a read happens in the same cycle. Reads return the words in arrival order.
- R2: A read while the store is empty returns zero on read data and leaves the fill level unchanged. Read data is also zero whenever the store is empty or reception is disabled.
- R3: The full flag is 1 exactly when reception is enabled and the store holds DEPTH words (16 by default). A read taken from a full store with no write drops the flag on the next cycle.
- R4: A write that finds the store full, with no read in the same cycle, is discarded and sets the overflow output. The overflow output stays set until reception is disabled. The stored words and their order are unaffected.
- R5: The data-request flag is 1 when reception is enabled and the fill level is strictly greater than the watermark input.
- R6: The data-request flag is 0 whenever the fill level is less than or equal to the watermark.
- R7: A DMA acknowledge accepted while reception is enabled forces the data-request flag to 0 for the following cycle. In the cycle after that, the flag again follows R5 and R6.
- R8: While reception is disabled, the full, data-request, DMA request and interrupt outputs are 0 in the same cycle. Each clock edge with reception disabled empties the store and clears overflow, and writes are ignored.
- R9: The DMA request output equals the data-request flag when DMA mode is 1, and is 0 otherwise.
- R10: The interrupt output is the OR of two terms: the full flag ANDed with its enable, and the data-request flag ANDed with its enable and with DMA mode being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Reception enable; low flushes the store and masks the flags |
| wr_valid | input | 1 | Write strobe from the deserializer |
| wr_data | input | DATA_W | Received word |
| rd_en | input | 1 | Read strobe of the receive data register |
| rd_data | output | DATA_W | Oldest stored word, or zero when empty |
| dma_ack | input | 1 | DMA access acknowledge strobe |
| wm | input | PTR_W | Watermark; request when level is greater than this |
| ie_full | input | 1 | Interrupt enable for the full flag |
| ie_req | input | 1 | Interrupt enable for the data-request flag |
| dma_mode | input | 1 | Routes the data-request flag to the DMA request output |
| full_flag | output | 1 | Store holds DEPTH words |
| req_flag | output | 1 | Fill level above watermark |
| dma_req | output | 1 | DMA transfer request |
| irq | output | 1 | Combined interrupt |
| ovf | output | 1 | Sticky overflow indicator |

## Verification
The bench sweeps every watermark value. For each one it fills the store one word at a time up to and past capacity, then drains it down to an empty read. A comparison that used greater-or-equal, or that was off by one, would show the request flag one level early or late. An extra write at capacity catches a design that overwrites the oldest word, wraps its level count, or forgets the sticky overflow. A read-past-empty catches a level that underflows. Separate cases pair a DMA acknowledge with and without a read, to show the request drops for exactly one cycle. Other cases drop reception enable with words stored and writes pending, and walk every interrupt-enable and DMA-mode combination on a full store.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

   // interrupt source slots used by the combiner
   typedef enum int {
      SRC_FULL = 0,
      SRC_REQ  = 1
   } irq_src_e;

   localparam int NUM_IRQ_SRC = 2;

endpackage

// File: rtl/rxwm_store.sv
module rxwm_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  cnt,
   output logic              ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
   localparam bit               IS_POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   initial begin : param_chk
      assert (DEPTH >= 2) else $fatal(1, "rxwm_store: DEPTH must be at least 2");
      assert (PTR_W >= $clog2(DEPTH)) else $fatal(1, "rxwm_store: PTR_W too narrow");
      assert (CNT_W >= $clog2(DEPTH + 1)) else $fatal(1, "rxwm_store: CNT_W too narrow");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              is_full, is_empty, pop, push, drop;

   assign is_full  = (cnt == CNT_MAX);
   assign is_empty = (cnt == '0);
   assign pop      = rx_en && rd_en && !is_empty;
   assign push     = rx_en && wr_valid && (!is_full || pop);
   assign drop     = rx_en && wr_valid && is_full && !pop;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovf    <= 1'b0;
      end else if (!rx_en) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         ovf    <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         unique case ({push, pop})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
         if (drop) ovf <= 1'b1;
      end
   end

   assign rd_data = (rx_en && !is_empty) ? mem[rd_ptr] : '0;

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);

   // R8
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (cnt == '0) && !ovf);

   // R2
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && is_empty && !wr_valid) |=> (cnt == '0));

endmodule

// File: rtl/rxwm_flags.sv
module rxwm_flags #(
   parameter int DEPTH = 16,
   parameter int PTR_W = 4,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [PTR_W-1:0] wm,
   input  logic             dma_ack,
   output logic             full_flag,
   output logic             req_flag
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   initial begin : param_chk
      assert (CNT_W > PTR_W) else $fatal(1, "rxwm_flags: CNT_W must exceed PTR_W");
   end

   logic ack_hold_q;
   logic above;

   assign above = (cnt > CNT_W'(wm));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_hold_q <= 1'b0;
      else        ack_hold_q <= rx_en && dma_ack;
   end

   assign full_flag = rx_en && (cnt == CNT_MAX);
   assign req_flag  = rx_en && above && !ack_hold_q;

   // R7
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && dma_ack) |=> !req_flag);

endmodule

// File: rtl/rxwm_irq.sv
module rxwm_irq
   import rxwm_pkg::*;
#(
   parameter int NSRC = NUM_IRQ_SRC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_flag,
   input  logic [NSRC-1:0] src_en,
   input  logic [NSRC-1:0] src_mask,
   output logic            irq
);

   initial begin : param_chk
      assert (NSRC >= 1) else $fatal(1, "rxwm_irq: need at least one source");
   end

   logic [NSRC-1:0] term;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign term[i] = src_flag[i] && src_en[i] && !src_mask[i];
      end
   endgenerate

   assign irq = |term;

   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((src_flag & src_en) != '0));

endmodule

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo
   import rxwm_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int DEPTH  = 16,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              dma_ack,
   input  logic [PTR_W-1:0]  wm,
   input  logic              ie_full,
   input  logic              ie_req,
   input  logic              dma_mode,
   output logic              full_flag,
   output logic              req_flag,
   output logic              dma_req,
   output logic              irq,
   output logic              ovf
);

   initial begin : param_chk
      assert (DATA_W >= 1) else $fatal(1, "rx_wm_fifo: DATA_W must be positive");
   end

   logic [CNT_W-1:0]       cnt;
   logic [NUM_IRQ_SRC-1:0] src_flag, src_en, src_mask;

   rxwm_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .PTR_W  (PTR_W),
      .CNT_W  (CNT_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_data  (rd_data),
      .cnt      (cnt),
      .ovf      (ovf)
   );

   rxwm_flags #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W),
      .CNT_W (CNT_W)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .cnt       (cnt),
      .wm        (wm),
      .dma_ack   (dma_ack),
      .full_flag (full_flag),
      .req_flag  (req_flag)
   );

   assign dma_req = req_flag && dma_mode;

   always_comb begin
      src_flag           = '0;
      src_en             = '0;
      src_mask           = '0;
      src_flag[SRC_FULL] = full_flag;
      src_en[SRC_FULL]   = ie_full;
      src_flag[SRC_REQ]  = req_flag;
      src_en[SRC_REQ]    = ie_req;
      src_mask[SRC_REQ]  = dma_mode;
   end

   rxwm_irq #(
      .NSRC (NUM_IRQ_SRC)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_flag (src_flag),
      .src_en   (src_en),
      .src_mask (src_mask),
      .irq      (irq)
   );

   // R3
   full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_flag && rd_en && !wr_valid) |=> !full_flag);

   // R9
   dma_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (req_flag && dma_mode));

   // R8
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !full_flag && !req_flag && !dma_req && !irq);

endmodule

// File: tb/tb_rx_wm_fifo.sv
module tb_rx_wm_fifo;

   localparam int DW    = 32;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rx_en, wr_valid, rd_en, dma_ack;
   logic [DW-1:0] wr_data, rd_data;
   logic [3:0]    wm;
   logic          ie_full, ie_req, dma_mode;
   logic          full_flag, req_flag, dma_req, irq, ovf;

   int total = 0;
   int bad   = 0;

   logic [DW-1:0] mq[$];
   bit            m_hold;
   bit            m_ovf;

   always #5 clk = ~clk;

   rx_wm_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .dma_ack(dma_ack),
      .wm(wm), .ie_full(ie_full), .ie_req(ie_req), .dma_mode(dma_mode),
      .full_flag(full_flag), .req_flag(req_flag), .dma_req(dma_req),
      .irq(irq), .ovf(ovf)
   );

   task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit e_full();
      return rx_en && (mq.size() == DEPTH);
   endfunction

   function automatic bit e_req();
      return rx_en && (mq.size() > int'(wm)) && !m_hold;
   endfunction

   task automatic check_flags();
      chk(32'(full_flag), 32'(e_full()), "R3 full_flag");
      chk(32'(req_flag), 32'(e_req()), "R5 R6 R7 req_flag");
      chk(32'(dma_req), 32'(e_req() && dma_mode), "R9 dma_req");
      chk(32'(irq), 32'((e_full() && ie_full) || (e_req() && ie_req && !dma_mode)), "R10 irq");
      chk(32'(ovf), 32'(m_ovf), "R4 ovf");
   endtask

   task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r, input bit a);
      bit pop, push, full;
      @(negedge clk);
      wr_valid = w; wr_data = d; rd_en = r; dma_ack = a;
      #1;
      chk(rd_data, (rx_en && mq.size() > 0) ? mq[0] : '0, "R1 R2 rd_data");
      @(posedge clk);
      if (!rx_en) begin
         mq.delete();
         m_ovf  = 0;
         m_hold = 0;
      end else begin
         full = (mq.size() == DEPTH);
         pop  = r && (mq.size() > 0);
         push = w && (!full || pop);
         if (w && full && !pop) m_ovf = 1;
         if (pop)  void'(mq.pop_front());
         if (push) mq.push_back(d);
         m_hold = a;
      end
      #1;
      wr_valid = 0; rd_en = 0; dma_ack = 0;
      check_flags();
   endtask

   initial begin : watchdog
      #(200000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      rst_n = 0; rx_en = 0; wr_valid = 0; rd_en = 0; dma_ack = 0;
      wr_data = '0; wm = '0; ie_full = 0; ie_req = 0; dma_mode = 0;
      m_hold = 0; m_ovf = 0;
      repeat (3) @(posedge clk);
      #1;
      // reset state, R8 disabled
      check_flags();
      chk(rd_data, '0, "R2 reset rd_data");
      @(negedge clk);
      rst_n = 1; rx_en = 1;

      // sweep watermarks: fill past full, drain past empty (R1 R2 R3 R4 R5 R6)
      for (int w = 0; w < DEPTH; w++) begin
         wm = 4'(w); ie_full = 1; ie_req = 1; dma_mode = w[0];
         for (int i = 0; i <= DEPTH; i++) cyc(1, {8'hA5, 8'(w), 16'(i)}, 0, 0);
         chk(32'(ovf), 1, "R4 overflow sticky");
         for (int i = 0; i <= DEPTH; i++) cyc(0, '0, 1, 0);
         cyc(0, '0, 1, 0);
         @(negedge clk); rx_en = 0;
         cyc(0, '0, 0, 0);
         @(negedge clk); rx_en = 1;
      end

      // read while full with simultaneous write keeps level (R1)
      wm = 4'd3; dma_mode = 0;
      for (int i = 0; i < DEPTH; i++) cyc(1, 32'h1000 + i, 0, 0);
      cyc(1, 32'h2000, 1, 0);
      chk(32'(full_flag), 1, "R1 push with pop at full");
      chk(32'(ovf), 0, "R4 no overflow with pop");

      // R7: acknowledge drops request for one cycle
      @(negedge clk); dma_mode = 1;
      cyc(0, '0, 1, 1);
      chk(32'(req_flag), 0, "R7 drop after ack");
      cyc(0, '0, 0, 0);
      chk(32'(req_flag), 1, "R7 reassert");
      cyc(0, '0, 0, 1);
      chk(32'(dma_req), 0, "R7 ack without read");
      cyc(0, '0, 0, 0);
      chk(32'(dma_req), 1, "R9 dma_req back");

      // R10: every enable combination on a full store
      while (mq.size() < DEPTH) cyc(1, 32'h3000 + mq.size(), 0, 0);
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         ie_full = c[0]; ie_req = c[1]; dma_mode = c[2];
         cyc(0, '0, 0, 0);
      end

      // R8: disable with data held and a pending write
      @(negedge clk); rx_en = 0; #1;
      chk(32'(full_flag | req_flag | dma_req | irq), 0, "R8 flags masked");
      chk(rd_data, '0, "R8 rd_data masked");
      cyc(1, 32'hDEAD, 0, 0);
      cyc(1, 32'hBEEF, 0, 0);
      @(negedge clk); rx_en = 1; wm = 4'd0;
      cyc(0, '0, 0, 0);
      chk(32'(req_flag), 0, "R8 flushed level");
      cyc(0, '0, 1, 0);
      cyc(1, 32'h77, 0, 0);
      chk(32'(req_flag), 1, "R5 one word above zero");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule